// File: doc/BRIEF.md
# SPI Master Controller with Transmit and Receive Queues

This block is a register-mapped SPI master. Software writes outgoing words into a four-entry transmit queue through a data register. An internal engine takes the oldest queued word, asserts the single active-low select line and shifts the word out MSB first in clock mode 0. It gathers the bits on the input line at the same time. Each completed incoming frame is stored in a four-entry receive queue, and a read of the data register removes the oldest one. Frames are 8 or 16 bits wide, and the serial clock is derived from the system clock by a programmable divider.

After a frame ends, a programmable delay can hold the select line high before the next frame begins, and a status flag reports that hold-off. A stop control lets the current frame finish but keeps any further frame from starting. Status flags report whether each queue has room or data, whether the engine is idle and whether a receive overrun took place. The register port uses single-cycle strobes. Back-pressure on writes comes from the transmit-ready flag: software must check it, because a data write made while the transmit queue is full is discarded. A data read of an empty receive queue returns zero and changes nothing.

Register map (`reg_addr`): 0 is data, 1 is status, 2 is control. Control fields are: bits [7:0] divider, bits [11:8] gap count, bit 12 frame width (1 = 16 bits), bit 13 stop. Status bits are: 0 receive-ready, 1 transmit-ready, 2 idle, 3 gap, 4 overrun.

Top module: `spi_fifo_master`

## Requirements
- R1: A write to address 0 queues `reg_wdata`. Frames leave in write order, MSB first on `spi_mosi`, with `spi_cs_n` low for the whole frame. `spi_sclk` is low while selected-off, rises 8 or 16 times per frame, and `spi_mosi` changes only while `spi_sclk` falls or at frame start.
- R2: Control bit 12 picks the frame width: 1 gives 16 bits, 0 gives 8 bits using `reg_wdata[7:0]`. A data read returns the received frame in bits [15:0]. Bits [15:8] read as zero in 8-bit mode, and bits [31:16] always read as zero.
- R3: One `spi_sclk` period lasts 2×(divider+1) system clocks, with the divider in control bits [7:0].
- R4: Each completed frame stores the bits sampled on `spi_miso` at the rising `spi_sclk` edges in the receive queue. A data read returns and removes the oldest entry.
- R5: Status bit 1 is 1 when the transmit queue has a free entry and 0 when all 4 entries are used. A data write made while the queue is full is dropped.
- R6: Status bit 0 is 1 exactly while the receive queue holds data. It clears when a read takes out the last entry.
- R7: A frame that completes while the receive queue holds 4 entries is discarded and sets status bit 4. That bit stays set until a status read.
- R8: When control bits [11:8] hold N>0, `spi_cs_n` stays high after every frame for 2·N·(divider+1) system clocks before the next frame can start (which adds one cycle), and status bit 3 is 1 during that time. When N=0, the next frame starts one cycle after the previous one ends and status bit 3 never becomes 1.
- R9: While control bit 13 is set, a frame already shifting runs to completion and no new frame starts. Clearing the bit lets queued frames resume.
- R10: Status bit 2 is 1 exactly when no frame or gap is in progress and either the transmit queue is empty or control bit 13 is set.
- R11: After reset, status reads 0x06, `spi_cs_n` is 1 and `spi_sclk` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle; pops data or clears overrun |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
If a queue pointer goes wrong, the port shows frames out of order or repeated within one frame time, and the status flags read out of step with the number of writes. If the shift counter goes wrong, the frame shows the wrong number of clock pulses before select rises, and this can be seen as soon as that frame ends. If the gap counter or the stop gating goes wrong, the high time of the select line between frames changes, or a frame starts during a stop. The bench measures both in whole clock cycles at the next frame boundary.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W  = 16;
  localparam int DIV_W   = 8;
  localparam int GAP_W   = 4;
  localparam int REG_W   = 32;
  localparam int CTRL_W  = DIV_W + GAP_W + 2;
  localparam int CB_WIDE = DIV_W + GAP_W;
  localparam int CB_STOP = DIV_W + GAP_W + 1;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp, level;

  assign level = wp - rp;
  assign full  = (level == (AW+1)'(DEPTH));
  assign empty = (wp == rp);
  assign rdata = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= wdata;
  end

  // R5: a push into a full queue leaves the write pointer untouched
  a_r5_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(wp));

  // R6: taking out the only entry leaves the queue empty
  a_r6_last_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 1 && pop && !push) |=> empty);
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic [GAP_W-1:0]  gap,
  input  logic              wide,
  input  logic              stop,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              in_gap,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BITS_W = $clog2(DATA_W + 1);

  eng_state_t        st;
  logic [DIV_W-1:0]  hcnt;
  logic [GAP_W:0]    gcnt;
  logic [BITS_W-1:0] bits;
  logic [DATA_W-1:0] sh_tx, sh_rx;
  logic              wide_q, tick, last_fall;

  assign tick      = (hcnt == div);
  assign last_fall = (st == ENG_SHIFT) && tick && sclk && (bits == BITS_W'(1));
  assign tx_pop    = (st == ENG_IDLE) && !tx_empty && !stop;
  assign rx_push   = last_fall;
  assign rx_data   = wide_q ? sh_rx : {{HALF_W{1'b0}}, sh_rx[HALF_W-1:0]};
  assign busy      = (st != ENG_IDLE);
  assign in_gap    = (st == ENG_GAP);
  assign mosi      = sh_tx[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ENG_IDLE;
      hcnt   <= '0;
      gcnt   <= '0;
      bits   <= '0;
      sh_tx  <= '0;
      sh_rx  <= '0;
      wide_q <= 1'b0;
      sclk   <= 1'b0;
      cs_n   <= 1'b1;
    end else begin
      case (st)
        ENG_IDLE: begin
          if (tx_pop) begin
            st     <= ENG_SHIFT;
            cs_n   <= 1'b0;
            sclk   <= 1'b0;
            hcnt   <= '0;
            wide_q <= wide;
            sh_rx  <= '0;
            sh_tx  <= wide ? tx_data : {tx_data[HALF_W-1:0], {HALF_W{1'b0}}};
            bits   <= wide ? BITS_W'(DATA_W) : BITS_W'(HALF_W);
          end
        end
        ENG_SHIFT: begin
          if (!tick) begin
            hcnt <= hcnt + 1'b1;
          end else begin
            hcnt <= '0;
            if (!sclk) begin
              sclk  <= 1'b1;
              sh_rx <= {sh_rx[DATA_W-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (bits > BITS_W'(1)) begin
                bits  <= bits - 1'b1;
                sh_tx <= {sh_tx[DATA_W-2:0], 1'b0};
              end else begin
                cs_n <= 1'b1;
                if (gap != '0) begin
                  st   <= ENG_GAP;
                  gcnt <= {gap, 1'b0};
                end else begin
                  st <= ENG_IDLE;
                end
              end
            end
          end
        end
        ENG_GAP: begin
          if (!tick) begin
            hcnt <= hcnt + 1'b1;
          end else begin
            hcnt <= '0;
            if (gcnt <= (GAP_W+1)'(1)) st <= ENG_IDLE;
            else                        gcnt <= gcnt - 1'b1;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  // R1: the serial clock stays low whenever the select line is high
  a_r1_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R8: the select line is high throughout the gap
  a_r8_gap_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> cs_n);

  // R9: no frame starts while stop is held
  a_r9_hold_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ENG_IDLE && stop) |=> (st == ENG_IDLE));

  // R1: serial data holds still across a rising serial clock
  a_r1_mosi_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $rose(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [DATA_W-1:0] rx_head,
  input  logic              rx_empty,
  input  logic              rx_drop,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              busy,
  input  logic              in_gap,
  output logic              tx_push,
  output logic              rx_pop,
  output logic [DIV_W-1:0]  div,
  output logic [GAP_W-1:0]  gap,
  output logic              wide,
  output logic              stop,
  output logic              idle
);
  localparam int HALF_W = DATA_W / 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ovr_q, stat_rd;
  logic [DATA_W-1:0] rd_word;
  logic [4:0]        stat;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[REG_W-1:CTRL_W];

  assign div  = ctrl_q[DIV_W-1:0];
  assign gap  = ctrl_q[DIV_W+GAP_W-1:DIV_W];
  assign wide = ctrl_q[CB_WIDE];
  assign stop = ctrl_q[CB_STOP];
  assign idle = !busy && (tx_empty || stop);

  assign tx_push = reg_wr && (reg_addr == ADDR_DATA);
  assign rx_pop  = reg_rd && (reg_addr == ADDR_DATA);
  assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

  always_comb begin
    if (rx_empty)  rd_word = '0;
    else if (wide) rd_word = rx_head;
    else           rd_word = {{HALF_W{1'b0}}, rx_head[HALF_W-1:0]};
  end

  assign stat = {ovr_q, in_gap, idle, !tx_full, !rx_empty};

  always_comb begin
    case (reg_addr)
      ADDR_DATA: reg_rdata = {{(REG_W-DATA_W){1'b0}}, rd_word};
      ADDR_STAT: reg_rdata = {{(REG_W-5){1'b0}}, stat};
      ADDR_CTRL: reg_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (rx_drop)      ovr_q <= 1'b1;
      else if (stat_rd) ovr_q <= 1'b0;
    end
  end

  // R7: overrun stays set until a status read
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !stat_rd) |=> ovr_q);

  // R7: a dropped frame always raises overrun
  a_r7_drop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> ovr_q);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic [DATA_W-1:0] tx_head;
  logic              rx_push, rx_pop, rx_full, rx_empty, rx_drop;
  logic [DATA_W-1:0] rx_head, rx_word;
  logic [DIV_W-1:0]  div;
  logic [GAP_W-1:0]  gap;
  logic              wide, stop, busy, in_gap, idle;

  assign rx_drop = rx_push && rx_full;

  spim_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .rx_head, .rx_empty, .rx_drop, .tx_full, .tx_empty, .busy, .in_gap,
    .tx_push, .rx_pop, .div, .gap, .wide, .stop, .idle
  );

  spim_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk, .rst_n, .push(tx_push), .wdata(reg_wdata[DATA_W-1:0]), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk, .rst_n, .push(rx_push), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_head), .full(rx_full), .empty(rx_empty)
  );

  spim_engine u_eng (
    .clk, .rst_n, .div, .gap, .wide, .stop, .tx_empty, .tx_data(tx_head),
    .tx_pop, .rx_push, .rx_data(rx_word), .busy, .in_gap,
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  // R10: the idle flag never shows while a frame holds the select line low
  a_r10_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> spi_cs_n);
endmodule

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  spi_fifo_master i_spi_fifo_master (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, errors = 0, cyc = 0, frames = 0, rx_cnt = 0;
  int exp_period = 4, last_gap = 0, last_rise = 0, last_sclk = 0, mon_n = 0;
  bit mode16 = 1'b0, mon_wide = 1'b0, mon_act = 1'b0, done = 1'b0;
  logic [15:0] tx_q[$], rx_q[$];
  logic [15:0] mon_sh, s_sh, cur_resp;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input int dv, input int gp, input bit w, input bit st);
    return {18'h0, st, w, 4'(gp), 8'(dv)};
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // driver: queue the word and remember what must appear on the line
  task automatic send(input logic [15:0] v);
    wr_reg(2'd0, {16'h0, v});
    tx_q.push_back(v);
  endtask

  task automatic read_rx(input string req);
    logic [31:0] d;
    logic [15:0] e;
    rd_reg(2'd0, d);
    e = rx_q.pop_front();
    rx_cnt--;
    chk(d == {16'h0, e}, req, d, {16'h0, e});
  endtask

  task automatic wait_frames(input int n);
    wait (frames >= n);
    repeat (6) @(posedge clk);
  endtask

  // slave model: answer depends on frame number
  always @(negedge spi_cs_n) begin
    mon_act  = 1'b1;
    mon_n    = 0;
    mon_sh   = '0;
    mon_wide = mode16;
    if (frames > 0) last_gap = cyc - last_rise;
    cur_resp = 16'hC35A ^ (16'(frames) * 16'h0F1D);
    s_sh     = cur_resp;
    spi_miso = mon_wide ? s_sh[15] : s_sh[7];
  end

  always @(negedge spi_sclk) begin
    if (spi_cs_n === 1'b0) begin
      s_sh     = s_sh << 1;
      spi_miso = mon_wide ? s_sh[15] : s_sh[7];
    end
  end

  // monitor: rebuild each frame from the line
  always @(posedge spi_sclk) begin
    if (spi_cs_n === 1'b0) begin
      if (mon_n > 0) chk(cyc - last_sclk == exp_period, "R3 sclk period", cyc - last_sclk, exp_period);
      last_sclk = cyc;
      mon_sh = {mon_sh[14:0], spi_mosi};
      mon_n++;
    end
  end

  always @(posedge spi_cs_n) begin
    if (mon_act) begin
      logic [15:0] e, got;
      mon_act   = 1'b0;
      last_rise = cyc;
      chk(mon_n == (mon_wide ? 16 : 8), "R1 clock pulses per frame", mon_n, mon_wide ? 16 : 8);
      e   = (tx_q.size() > 0) ? tx_q.pop_front() : 16'hxxxx;
      got = mon_wide ? mon_sh : {8'h0, mon_sh[7:0]};
      if (!mon_wide) e = {8'h0, e[7:0]};
      chk(got === e, "R1 R2 frame bits on mosi", got, e);
      if (rx_cnt < 4) begin
        rx_q.push_back(mon_wide ? cur_resp : {8'h0, cur_resp[7:0]});
        rx_cnt++;
      end
      frames++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    bit seen;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state
    rd_reg(2'd1, d);
    chk(d == 32'h6, "R11 status after reset", d, 32'h6);
    chk(spi_cs_n === 1'b1, "R11 cs_n after reset", spi_cs_n, 1);
    chk(spi_sclk === 1'b0, "R11 sclk after reset", spi_sclk, 0);

    // R1 R4 R6: 8-bit frames, divider 1
    exp_period = 4; mode16 = 0;
    wr_reg(2'd2, cw(1, 0, 0, 0));
    send(16'h00A5); send(16'h003C); send(16'h1281);
    wait_frames(3);
    rd_reg(2'd1, d);
    chk(d[0] == 1'b1, "R6 rx ready with data", d[0], 1);
    read_rx("R4 R2 first 8-bit read");
    read_rx("R4 second 8-bit read");
    read_rx("R4 third 8-bit read");
    rd_reg(2'd1, d);
    chk(d[0] == 1'b0, "R6 rx ready clears after last read", d[0], 0);
    rd_reg(2'd0, d);
    chk(d == 32'h0, "R6 empty data read returns zero", d, 0);

    // R2: 16-bit frames
    mode16 = 1;
    wr_reg(2'd2, cw(1, 0, 1, 0));
    send(16'hBEEF); send(16'h0123);
    wait_frames(5);
    read_rx("R2 first 16-bit read");
    read_rx("R2 second 16-bit read");

    // R3: divider 3
    mode16 = 0; exp_period = 8;
    wr_reg(2'd2, cw(3, 0, 0, 0));
    send(16'h005A);
    wait_frames(6);
    read_rx("R3 read after slow frame");

    // R5 R9 R10: fill the queue with stop set
    exp_period = 4; base = frames;
    wr_reg(2'd2, cw(1, 0, 0, 1));
    send(16'h0011); send(16'h0022); send(16'h0033);
    rd_reg(2'd1, d);
    chk(d[1] == 1'b1, "R5 tx ready with 3 queued", d[1], 1);
    send(16'h0044);
    rd_reg(2'd1, d);
    chk(d[1] == 1'b0, "R5 tx ready low when full", d[1], 0);
    chk(d[2] == 1'b1, "R10 idle while stopped with queued words", d[2], 1);
    wr_reg(2'd0, 32'h0000_0099);
    repeat (200) @(posedge clk);
    chk(frames == base, "R9 no frame while stopped", frames, base);
    chk(spi_cs_n === 1'b1, "R9 select high while stopped", spi_cs_n, 1);
    wr_reg(2'd2, cw(1, 0, 0, 0));
    wait_frames(base + 4);
    repeat (200) @(posedge clk);
    chk(frames == base + 4, "R5 write to full queue dropped", frames, base + 4);

    // R7: overrun
    rd_reg(2'd1, d);
    chk(d[4] == 1'b0, "R7 no overrun with 4 held", d[4], 0);
    send(16'h0055); send(16'h0066);
    wait_frames(base + 6);
    rd_reg(2'd1, d);
    chk(d[4] == 1'b1, "R7 overrun set", d[4], 1);
    rd_reg(2'd1, d);
    chk(d[4] == 1'b0, "R7 overrun cleared by status read", d[4], 0);
    repeat (4) read_rx("R7 kept frames intact");
    rd_reg(2'd1, d);
    chk(d[0] == 1'b0, "R6 rx empty after drain", d[0], 0);

    // R8: gap of 3
    base = frames; seen = 0;
    wr_reg(2'd2, cw(1, 3, 0, 0));
    send(16'h0081); send(16'h0042); send(16'h00C3);
    do begin
      rd_reg(2'd1, d);
      if (d[3]) seen = 1;
    end while (!(frames >= base + 3 && d[2]));
    chk(seen, "R8 gap flag seen", seen, 1);
    chk(last_gap == 13, "R8 select high time with gap 3", last_gap, 13);
    repeat (3) read_rx("R8 reads after gapped frames");

    // R8: gap of 0
    base = frames; seen = 0;
    wr_reg(2'd2, cw(1, 0, 0, 0));
    send(16'h0017); send(16'h0071);
    do begin
      rd_reg(2'd1, d);
      if (d[3]) seen = 1;
    end while (!(frames >= base + 2 && d[2]));
    chk(!seen, "R8 gap flag never set with gap 0", seen, 0);
    chk(last_gap == 1, "R8 back-to-back frames", last_gap, 1);
    repeat (2) read_rx("R8 reads after back-to-back frames");

    // R9: stop during a frame
    exp_period = 8; base = frames;
    wr_reg(2'd2, cw(3, 0, 0, 0));
    send(16'h00E7); send(16'h0018);
    wait (spi_cs_n === 1'b0);
    wr_reg(2'd2, cw(3, 0, 0, 1));
    wait (frames >= base + 1);
    repeat (150) @(posedge clk);
    chk(frames == base + 1, "R9 running frame completes, next held", frames, base + 1);
    rd_reg(2'd1, d);
    chk(d[2:1] == 2'b11, "R10 idle with stop and queued word", d[2:1], 2'b11);
    wr_reg(2'd2, cw(3, 0, 0, 0));
    wait_frames(base + 2);
    rd_reg(2'd1, d);
    chk(d[2] == 1'b1, "R10 idle after queue drains", d[2], 1);
    repeat (2) read_rx("R9 reads after resumed frames");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule